// File: doc/BRIEF.md
# Serial NAND Cached Page Reader

This block turns a byte-addressed read request into the command traffic a serial NAND device needs, and returns the requested bytes on a valid/ready stream. A request gives a start byte address and a length. The engine splits the request at page boundaries. For each page it needs, it first checks an external bad-block bitmap. It then moves the page from the array into the device's on-die cache and polls the status register until the device is no longer busy. It reads the on-die ECC verdict and then streams the bytes out of the cache.

The engine remembers the last row it loaded successfully. A later pass that falls in that row skips the array load and goes straight to the cache read. An invalidate input makes the engine forget that row; system logic pulses it after any program or erase. The SPI side is a one-byte-at-a-time exchange with a byte master. The engine holds `spi_req_o` with the byte to send and a frame-end flag. The master answers with a one-cycle `spi_ack_i` that carries the received byte. Chip select stays low across bytes until a byte flagged with `spi_end_o` completes.

The output stream follows valid/ready rules. Once `out_valid_o` is high, it stays high and `out_data_o` holds its value until `out_ready_i` is seen high on a clock edge. While an output byte waits, the engine asks the master for no further data byte, so back-pressure stalls the SPI frame rather than overflowing a buffer.

Top module: `snand_page_reader`

## Requirements
- R1: The row is the byte address shifted right by COL_W, and the column is its low COL_W bits. A page load is one frame of exactly four bytes: 0x13, 0x00, row high byte, row low byte. It is followed by status frames of exactly three bytes (0x0F, 0xC0, one filler byte), repeated until received bit 0 is clear.
- R2: The array load is skipped when the row equals the remembered row. After reset no row is remembered.
- R3: Before a row that misses is loaded, the bitmap is looked up at index row >> BLK_SHIFT on `bb_block_o`. A set `bb_bad_i` ends the request with error code 2, and no load frame is issued.
- R4: The ECC verdict is status bits [5:4]. A value of 1 sets `ecc_fixed_o` and the read continues. A value of 2 ends the request with error code 2 and leaves no row remembered. Values 0 and 3 count as clean.
- R5: A cache read frame is 0x03, column high byte, column low byte, one dummy byte, then the data bytes in the same frame. `spi_end_o` is raised only on the final data byte of the pass.
- R6: One pass reads no further than the end of the current page. The next pass starts at column 0 of the following row, and the bytes arrive in address order.
- R7: A zero-length request raises `done_o` in the cycle after it is accepted, with error code 0 and no SPI traffic. A request whose end lies beyond 2^ADDR_W bytes ends with error code 1 and no SPI traffic.
- R8: `byte_cnt_o` counts the bytes taken from the output stream during the current request. `ecc_fixed_o` stays set until the next request is accepted.
- R9: A pulse on `invalidate_i` makes the engine forget the remembered row, so the next read of that row reloads it.
- R10: `out_valid_o` and `out_data_o` hold steady while `out_ready_i` is low. Every streamed byte has been taken before `done_o` is raised.
- R11: If POLL_MAX status frames in a row all report busy, the request ends with error code 3 and no row is remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Accept a request while idle |
| addr_i | input | ADDR_W | Start byte address |
| len_i | input | ADDR_W+1 | Byte count |
| invalidate_i | input | 1 | Forget the remembered row |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 2 | 0 ok, 1 out of range, 2 uncorrectable or bad block, 3 device stuck busy |
| ecc_fixed_o | output | 1 | A corrected page was read in this request |
| byte_cnt_o | output | ADDR_W+1 | Bytes delivered in this request |
| bb_block_o | output | ADDR_W-COL_W-BLK_SHIFT | Bitmap lookup index |
| bb_bad_i | input | 1 | Lookup result, same cycle |
| spi_req_o | output | 1 | Byte exchange request |
| spi_tx_o | output | 8 | Byte to send |
| spi_end_o | output | 1 | Release chip select after this byte |
| spi_ack_i | input | 1 | Byte exchange finished |
| spi_rx_i | input | 8 | Byte received, valid with ack |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Stream sink ready |
| out_data_o | output | 8 | Stream byte |

## Verification
The bench builds the engine with ADDR_W=9, COL_W=4, BLK_SHIFT=2 and POLL_MAX=6. This gives a device of 32 rows of 16 bytes, grouped four rows to a block. With pages this short, a few dozen bytes cross several page boundaries, and a request can end exactly at the last device byte. A bad block, a corrected row, an uncorrectable row and a row that never leaves busy all sit within a small address range. The six-poll limit makes the stuck-device timeout short enough to reach in every run.

// File: rtl/snr_pkg.sv
package snr_pkg;
  typedef enum logic [1:0] {K_LOAD, K_POLL, K_CRD, K_DATA} kind_e;
  typedef enum logic [1:0] {EC_CLEAN, EC_FIXED, EC_FAIL} ecc_e;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_RANGE  = 2'd1;
  localparam logic [1:0] ERR_UNCORR = 2'd2;
  localparam logic [1:0] ERR_STUCK  = 2'd3;

  localparam logic [7:0] OP_LOAD  = 8'h13;
  localparam logic [7:0] OP_GETF  = 8'h0F;
  localparam logic [7:0] REG_STAT = 8'hC0;
  localparam logic [7:0] OP_CRD   = 8'h03;
endpackage

// File: rtl/snr_cmd_byte.sv
module snr_cmd_byte
  import snr_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int COL_W = 11
) (
  input  kind_e             kind_i,
  input  logic [2:0]        idx_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              data_last_i,
  output logic [7:0]        byte_o,
  output logic              end_o
);
  logic [15:0] row16;
  logic [15:0] col16;

  assign row16 = 16'(row_i);
  assign col16 = 16'(col_i);

  // Byte at position idx_i of the current frame kind.
  always_comb begin
    byte_o = 8'h00;
    end_o  = 1'b0;
    unique case (kind_i)
      K_LOAD: begin
        case (idx_i)
          3'd0:    byte_o = OP_LOAD;
          3'd2:    byte_o = row16[15:8];
          3'd3:    byte_o = row16[7:0];
          default: byte_o = 8'h00;
        endcase
        end_o = (idx_i == 3'd3);
      end
      K_POLL: begin
        case (idx_i)
          3'd0:    byte_o = OP_GETF;
          3'd1:    byte_o = REG_STAT;
          default: byte_o = 8'h00;
        endcase
        end_o = (idx_i == 3'd2);
      end
      K_CRD: begin
        case (idx_i)
          3'd0:    byte_o = OP_CRD;
          3'd1:    byte_o = col16[15:8];
          3'd2:    byte_o = col16[7:0];
          default: byte_o = 8'h00;
        endcase
        end_o = 1'b0;
      end
      default: begin
        byte_o = 8'h00;
        end_o  = data_last_i;
      end
    endcase
  end
endmodule

// File: rtl/snr_ecc_class.sv
module snr_ecc_class
  import snr_pkg::*;
(
  input  logic [1:0] ecc_bits_i,
  output ecc_e       cls_o
);
  always_comb begin
    unique case (ecc_bits_i)
      2'd1:    cls_o = EC_FIXED;
      2'd2:    cls_o = EC_FAIL;
      default: cls_o = EC_CLEAN;
    endcase
  end
endmodule

// File: rtl/snr_row_cache.sv
module snr_row_cache #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_i,
  input  logic             forget_i,
  input  logic             store_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '1;
      vld_q <= 1'b0;
    end else if (inv_i || forget_i) begin
      row_q <= '1;
      vld_q <= 1'b0;
    end else if (store_i) begin
      row_q <= row_i;
      vld_q <= 1'b1;
    end
  end

  assign hit_o = vld_q && (row_q == row_i);

  p_inv_forgets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> !hit_o);

  p_store_hits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_i && !inv_i && !forget_i) |=> hit_o);
endmodule

// File: rtl/snand_page_reader.sv
module snand_page_reader
  import snr_pkg::*;
#(
  parameter int ADDR_W    = 27,
  parameter int COL_W     = 11,
  parameter int BLK_SHIFT = 6,
  parameter int POLL_MAX  = 100
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [ADDR_W:0]                   len_i,
  input  logic                              invalidate_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic [1:0]                        err_o,
  output logic                              ecc_fixed_o,
  output logic [ADDR_W:0]                   byte_cnt_o,
  output logic [ADDR_W-COL_W-BLK_SHIFT-1:0] bb_block_o,
  input  logic                              bb_bad_i,
  output logic                              spi_req_o,
  output logic [7:0]                        spi_tx_o,
  output logic                              spi_end_o,
  input  logic                              spi_ack_i,
  input  logic [7:0]                        spi_rx_i,
  output logic                              out_valid_o,
  input  logic                              out_ready_i,
  output logic [7:0]                        out_data_o
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int LEN_W = ADDR_W + 1;
  localparam int PW    = $clog2(POLL_MAX + 1);
  localparam logic [COL_W:0] PAGE_BYTES = (COL_W+1)'(1) << COL_W;
  localparam logic [LEN_W:0] DEV_BYTES  = (LEN_W+1)'(1) << ADDR_W;

  typedef enum logic [2:0] {
    S_IDLE, S_PLAN, S_LOAD, S_POLL, S_CRD, S_DATA, S_NEXT, S_FIN
  } st_e;

  st_e              st_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] rem_q;
  logic [COL_W:0]   chunk_q;
  logic [2:0]       idx_q;
  logic [PW-1:0]    poll_q;
  logic [7:0]       out_q;
  logic             out_vld_q;
  logic [LEN_W-1:0] cnt_q;
  logic             fixed_q;
  logic [1:0]       err_q;

  logic             hit;
  logic             forget;
  logic             store;
  kind_e            kind;
  ecc_e             ecc_cls;
  logic [COL_W:0]   room;
  logic [COL_W:0]   take;
  logic [LEN_W:0]   end_sum;
  logic             accept;

  assign accept  = start_i && (st_q == S_IDLE);
  assign end_sum = {1'b0, LEN_W'(addr_i)} + {1'b0, len_i};
  assign room    = PAGE_BYTES - {1'b0, col_q};
  assign take    = (rem_q < LEN_W'(room)) ? rem_q[COL_W:0] : room;

  always_comb begin
    unique case (st_q)
      S_LOAD:  kind = K_LOAD;
      S_POLL:  kind = K_POLL;
      S_CRD:   kind = K_CRD;
      default: kind = K_DATA;
    endcase
  end

  snr_cmd_byte #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cmd (
    .kind_i      (kind),
    .idx_i       (idx_q),
    .row_i       (row_q),
    .col_i       (col_q),
    .data_last_i (chunk_q == (COL_W+1)'(1)),
    .byte_o      (spi_tx_o),
    .end_o       (spi_end_o)
  );

  snr_ecc_class u_ecc (
    .ecc_bits_i (spi_rx_i[5:4]),
    .cls_o      (ecc_cls)
  );

  // Row is forgotten as soon as a load starts; remembered again only on success.
  assign forget = (st_q == S_PLAN) && !hit && !bb_bad_i;
  assign store  = (st_q == S_POLL) && spi_ack_i && (idx_q == 3'd2) &&
                  !spi_rx_i[0] && (ecc_cls != EC_FAIL);

  snr_row_cache #(.ROW_W(ROW_W)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv_i    (invalidate_i),
    .forget_i (forget),
    .store_i  (store),
    .row_i    (row_q),
    .hit_o    (hit)
  );

  assign spi_req_o   = (st_q == S_LOAD) || (st_q == S_POLL) || (st_q == S_CRD) ||
                       ((st_q == S_DATA) && !out_vld_q);
  assign bb_block_o  = row_q[ROW_W-1:BLK_SHIFT];
  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_FIN);
  assign err_o       = err_q;
  assign ecc_fixed_o = fixed_q;
  assign byte_cnt_o  = cnt_q;
  assign out_valid_o = out_vld_q;
  assign out_data_o  = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      row_q     <= '0;
      col_q     <= '0;
      rem_q     <= '0;
      chunk_q   <= '0;
      idx_q     <= '0;
      poll_q    <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
      cnt_q     <= '0;
      fixed_q   <= 1'b0;
      err_q     <= ERR_NONE;
    end else begin
      if (out_vld_q && out_ready_i) begin
        out_vld_q <= 1'b0;
        cnt_q     <= cnt_q + 1'b1;
      end
      unique case (st_q)
        S_IDLE: begin
          if (accept) begin
            row_q   <= addr_i[ADDR_W-1:COL_W];
            col_q   <= addr_i[COL_W-1:0];
            rem_q   <= len_i;
            cnt_q   <= '0;
            fixed_q <= 1'b0;
            err_q   <= ERR_NONE;
            if (len_i == '0) begin
              st_q <= S_FIN;
            end else if (end_sum > DEV_BYTES) begin
              err_q <= ERR_RANGE;
              st_q  <= S_FIN;
            end else begin
              st_q <= S_PLAN;
            end
          end
        end
        S_PLAN: begin
          chunk_q <= take;
          idx_q   <= '0;
          if (hit) begin
            st_q <= S_CRD;
          end else if (bb_bad_i) begin
            err_q <= ERR_UNCORR;
            st_q  <= S_FIN;
          end else begin
            st_q <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (spi_ack_i) begin
            if (idx_q == 3'd3) begin
              idx_q  <= '0;
              poll_q <= '0;
              st_q   <= S_POLL;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        S_POLL: begin
          if (spi_ack_i) begin
            if (idx_q != 3'd2) begin
              idx_q <= idx_q + 1'b1;
            end else begin
              idx_q <= '0;
              if (spi_rx_i[0]) begin
                if (poll_q == PW'(POLL_MAX - 1)) begin
                  err_q <= ERR_STUCK;
                  st_q  <= S_FIN;
                end else begin
                  poll_q <= poll_q + 1'b1;
                end
              end else if (ecc_cls == EC_FAIL) begin
                err_q <= ERR_UNCORR;
                st_q  <= S_FIN;
              end else begin
                if (ecc_cls == EC_FIXED) fixed_q <= 1'b1;
                st_q <= S_CRD;
              end
            end
          end
        end
        S_CRD: begin
          if (spi_ack_i) begin
            if (idx_q == 3'd3) begin
              idx_q <= '0;
              st_q  <= S_DATA;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (spi_ack_i) begin
            out_q     <= spi_rx_i;
            out_vld_q <= 1'b1;
            rem_q     <= rem_q - 1'b1;
            chunk_q   <= chunk_q - 1'b1;
            if (chunk_q == (COL_W+1)'(1)) st_q <= S_NEXT;
          end
        end
        S_NEXT: begin
          if (!out_vld_q) begin
            if (rem_q == '0) begin
              st_q <= S_FIN;
            end else begin
              row_q <= row_q + 1'b1;
              col_q <= '0;
              st_q  <= S_PLAN;
            end
          end
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_req_o && !spi_ack_i) |=> (spi_req_o && $stable(spi_tx_o) && $stable(spi_end_o)));

  p_done_drained_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !out_valid_o);

  p_fixed_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_fixed_o && !accept) |=> ecc_fixed_o);

  p_zero_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (len_i == '0)) |=> (done_o && (err_o == ERR_NONE) && !spi_req_o));

  p_bad_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_PLAN) && !hit && bb_bad_i) |=> (done_o && !spi_req_o));
endmodule

// File: tb/snand_page_reader_tb_top.sv
module snand_page_reader_tb_top;
  localparam int AW = 9, CW = 4, BS = 2, PM = 6;
  localparam int LW = AW + 1, RW = AW - CW, BW = RW - BS;
  localparam int PG = 16, NROWS = 32, DEV = 512;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [LW-1:0] len = '0;
  logic          inv = 1'b0;
  logic          busy, done, fixed, bb_bad, spi_req, spi_end, out_valid;
  logic          out_ready = 1'b1;
  logic [1:0]    err;
  logic [LW-1:0] cnt;
  logic [BW-1:0] bb_block;
  logic [7:0]    spi_tx, out_data;
  logic          d_ack = 1'b0;
  logic          d_bsy = 1'b0;
  logic [7:0]    d_rx = 8'h00;

  snand_page_reader #(.ADDR_W(AW), .COL_W(CW), .BLK_SHIFT(BS), .POLL_MAX(PM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .len_i(len),
    .invalidate_i(inv), .busy_o(busy), .done_o(done), .err_o(err),
    .ecc_fixed_o(fixed), .byte_cnt_o(cnt), .bb_block_o(bb_block), .bb_bad_i(bb_bad),
    .spi_req_o(spi_req), .spi_tx_o(spi_tx), .spi_end_o(spi_end), .spi_ack_i(d_ack),
    .spi_rx_i(d_rx), .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  int checks = 0, fails = 0;
  int ecc_tab [NROWS];
  bit bad_tab [8];
  int stuck_row = 25;
  int m_last = -1;
  int loads = 0, nbytes = 0;
  bit bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] exp_q [$];

  assign bb_bad = bad_tab[bb_block];

  function automatic logic [7:0] mem_byte(input int r, input int c);
    return 8'((r * 16 + c) * 5 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural serial NAND device: one byte per exchange, ack two edges later.
  logic [7:0] f_op = 8'h00, r8 = 8'h00;
  int f_idx = 0, f_col = 0, f_rowh = 0, ld_row = 0, busy_left = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      d_ack <= 1'b0; d_bsy <= 1'b0; f_idx = 0;
    end else begin
      d_ack <= 1'b0;
      if (d_bsy) begin
        d_ack <= 1'b1; d_bsy <= 1'b0;
      end else if (spi_req && !d_ack) begin
        nbytes++;
        r8 = 8'hFF;
        if (f_idx == 0) f_op = spi_tx;
        case (f_op)
          8'h13: begin
            if (f_idx == 1) chk(spi_tx == 8'h00, "R1", "load pad byte", spi_tx, 0);
            if (f_idx == 2) f_rowh = spi_tx;
            if (f_idx == 3) begin ld_row = (f_rowh * 256 + spi_tx) % NROWS; loads++; busy_left = 2; end
          end
          8'h0F: begin
            if (f_idx == 1) chk(spi_tx == 8'hC0, "R1", "status reg byte", spi_tx, 'hC0);
            if (f_idx == 2) begin
              if (ld_row == stuck_row) r8 = 8'h01;
              else if (busy_left > 0) begin busy_left--; r8 = 8'h01; end
              else r8 = 8'(ecc_tab[ld_row] << 4);
            end
          end
          8'h03: begin
            if (f_idx == 1) f_col = spi_tx * 256;
            if (f_idx == 2) f_col = f_col + spi_tx;
            if (f_idx >= 4) r8 = mem_byte(ld_row, f_col + f_idx - 4);
          end
          default: chk(1'b0, "R1", "unknown opcode", f_op, 0);
        endcase
        if (spi_end) begin
          if (f_op == 8'h13) chk(f_idx == 3, "R1", "load frame length", f_idx + 1, 4);
          if (f_op == 8'h0F) chk(f_idx == 2, "R1", "status frame length", f_idx + 1, 3);
          if (f_op == 8'h03) begin
            chk(f_idx >= 4, "R5", "cache read has data", f_idx + 1, 5);
            chk(f_col + f_idx - 3 <= PG, "R6", "pass end column", f_col + f_idx - 3, PG);
          end
          f_idx = 0;
        end else begin
          f_idx++;
        end
        d_rx <= r8; d_bsy <= 1'b1;
      end
    end
  end

  // Stream sink: set ready for the coming edge, then compare the handshake.
  logic [7:0] held_d = 8'h00;
  bit held = 1'b0;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rst_n && held)
      chk(out_valid && out_data == held_d, "R10", "held byte", out_data, held_d);
    out_ready = bp ? (lfsr[0] & lfsr[2]) : 1'b1;
    held = 1'b0;
    if (rst_n && out_valid) begin
      if (out_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R6", "unexpected byte", out_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(out_data == e, "R6", "stream byte", out_data, e);
        end
      end else begin
        held = 1'b1; held_d = out_data;
      end
    end
  end

  task automatic run(input int a, input int n, input string tag);
    int e_err = 0, e_loads = 0, e_cnt = 0, r, c, rem, l0, b0, cyc;
    bit e_fix = 0;
    r = a >> CW; c = a & (PG - 1); rem = n;
    if (n != 0 && a + n > DEV) e_err = 1;
    else begin
      while (rem > 0) begin
        int take;
        take = (rem < PG - c) ? rem : PG - c;
        if (r != m_last) begin
          if (bad_tab[r >> BS]) begin e_err = 2; break; end
          e_loads++; m_last = -1;
          if (r == stuck_row) begin e_err = 3; break; end
          if (ecc_tab[r] == 2) begin e_err = 2; break; end
          if (ecc_tab[r] == 1) e_fix = 1;
          m_last = r;
        end
        for (int k = 0; k < take; k++) exp_q.push_back(mem_byte(r, c + k));
        e_cnt += take; rem -= take; r++; c = 0;
      end
    end
    l0 = loads; b0 = nbytes;
    @(negedge clk); start = 1'b1; addr = AW'(a); len = LW'(n);
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(cyc < 20000, tag, "watchdog", cyc, 0);
    chk(err == 2'(e_err), tag, "error code", err, e_err);
    chk(cnt == LW'(e_cnt), tag, "byte count R8", cnt, e_cnt);
    chk(fixed == e_fix, tag, "ecc corrected flag R4", fixed, e_fix);
    chk(loads - l0 == e_loads, tag, "page loads R2", loads - l0, e_loads);
    chk(exp_q.size() == 0, tag, "bytes missing", exp_q.size(), 0);
    if (n == 0 || e_err == 1) begin
      chk(cyc == 0, "R7", "done latency", cyc, 0);
      chk(nbytes == b0, "R7", "no SPI traffic", nbytes - b0, 0);
    end
    exp_q.delete();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NROWS; i++) ecc_tab[i] = 0;
    for (int i = 0; i < 8; i++) bad_tab[i] = 1'b0;
    ecc_tab[5] = 1; ecc_tab[9] = 2; bad_tab[3] = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !out_valid && !spi_req && err == 0 && cnt == 0 && !fixed,
        "R2", "reset state", {busy, done, out_valid, spi_req}, 0);

    run(0, 0, "R7");                   // zero length
    run(500, 20, "R7");                // past device end
    run(496, 16, "R6");                // ends exactly at last byte
    run('h23, 5, "R1");                // one load, mid-page
    run('h20, 16, "R2");               // same row: no reload
    bp = 1'b1;
    run('h1A, 40, "R6");               // four pages, back-pressure
    bp = 1'b0;
    run(4 * 16 + 8, 20, "R4");         // row 5 corrected, continues
    repeat (5) @(negedge clk);
    chk(fixed == 1'b1, "R8", "flag sticky while idle", fixed, 1);
    run(6 * 16, 4, "R8");              // new request clears flag
    run(8 * 16 + 12, 10, "R4");        // row 9 uncorrectable after 4 bytes
    run(8 * 16, 3, "R4");              // row 8 reloads: nothing remembered
    run(12 * 16 + 2, 6, "R3");         // bad block 3
    run(20 * 16, 8, "R9");
    @(negedge clk); inv = 1'b1; @(negedge clk); inv = 1'b0; m_last = -1;
    run(20 * 16 + 4, 8, "R9");         // reload after invalidate
    run(25 * 16, 4, "R11");            // stuck busy
    run(24 * 16, 4, "R11");            // neighbour still readable
    bp = 1'b1;
    run('h100, 60, "R10");             // random back-pressure
    run('h104, 8, "R10");
    bp = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule